// File: doc/BRIEF.md
# Cascadable Serial Configuration Memory

This block stores a configuration image as an array of bits and plays it out one bit per clock on a single serial output. A configuration master supplies the clock and reads the bit stream. It has no address bus. An internal bit counter starts at the first stored bit and moves forward on each rising clock edge while the chip-enable input is active. The current bit is presented on the data output.

A combined output-enable/reset pin does two jobs. While it is in its reset sense, the bit counter is cleared and the output is released. While it is in its enable sense, the output may drive. Which pin level means "reset" is chosen by a parameter.

When the last stored bit has been consumed, the block stops counting and releases the data line. It then asserts its cascade-enable output, which is wired to the chip-enable of the next memory. In this way, several memories share one clock and one data line and deliver their images back to back. The image is filled beforehand through a synchronous bit-wide load port, which is honoured only while the pin is in its reset sense. The data output comes as a value plus a drive-enable, so a pad cell outside the block can make it tri-state.

Top module: `sercfg_mem`

## Requirements
- R1: The reset sense of `oe_rst_i` follows `RST_POL`. With `RST_ACT_HIGH` (1), a high level resets the block and a low level enables the output. With `RST_ACT_LOW` (0), the meaning is inverted.
- R2: While `ce_ni` is low, the reset sense is inactive and the terminal count has not been reached, the bit counter advances by exactly one on every rising clock edge.
- R3: When `ce_ni` is high at a clock edge, the bit counter keeps its value, and `data_oe_o` is low while `ce_ni` is high.
- R4: `data_oe_o` is high only while `ce_ni` is low, the reset sense is inactive and the terminal count has not been reached. While it is high, `data_o` equals stored bit number N, where N is the counter value; bit 0 is played first.
- R5: A clock edge that samples the reset sense clears the counter to bit 0 and returns `ceo_no` to high.
- R6: The counting edge that leaves the last bit (index `DEPTH-1`) sets the terminal count. From then on, `ceo_no` is low, the counter holds and `data_oe_o` is low, until a reset.
- R7: A load write (`ld_we_i` high at a clock edge) stores `ld_bit_i` at bit index `ld_addr_i`, but only while the reset sense is active. Writes at other times, and writes to indices `DEPTH` or above, change nothing.
- R8: When instances are chained (`ceo_no` of one to `ce_ni` of the next, shared clock and data line), the line carries the first image followed at once by the second, and at most one instance drives in any cycle.
- R9: `rst_ni` low clears the counter and the terminal count at once, without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock; also clocks the load port |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| ce_ni | input | 1 | Chip enable, active low; sampled at each rising edge |
| oe_rst_i | input | 1 | Combined output-enable/reset pin, polarity set by `RST_POL` |
| ld_we_i | input | 1 | Load write strobe |
| ld_addr_i | input | $clog2(DEPTH) | Bit index to write |
| ld_bit_i | input | 1 | Bit value to write |
| data_o | output | 1 | Serial data bit (0 when not driving) |
| data_oe_o | output | 1 | Drive enable for the tri-state data pad |
| ceo_no | output | 1 | Cascade enable, active low, asserted from terminal count to reset |

## Verification
The bench builds two instances and chains them. The first has `DEPTH=12` and `RST_POL=RST_ACT_LOW`. The second has `DEPTH=8` and `RST_POL=RST_ACT_HIGH`. Driving one reset signal to the first and its inverse to the second exercises both polarities in the same run. A depth that is not a power of two leaves four load indices that are out of range, so the ignored writes can be observed in the stream. The short images make the hand-over at terminal count, a mid-stream chip-enable pause, and restarts through both reset paths all fit in a few dozen cycles.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

  // Which level of the combined output-enable/reset pin means "reset".
  typedef enum logic {
    RST_ACT_LOW  = 1'b0,
    RST_ACT_HIGH = 1'b1
  } rst_pol_e;

  // True when the pin level is in its reset sense for the given polarity.
  function automatic logic pol_asserted(rst_pol_e pol, logic pin);
    return (pol == RST_ACT_HIGH) ? pin : ~pin;
  endfunction

endpackage

// File: rtl/sercfg_addr_ctr.sv
module sercfg_addr_ctr #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [AW-1:0] cnt_o,
  output logic          tc_o
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] cnt_q, cnt_d;
  logic          tc_q, tc_d;
  logic          ld_en;

  // Next-state logic: clear has priority; counting stops at terminal count.
  always_comb begin
    cnt_d = cnt_q;
    tc_d  = tc_q;
    ld_en = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
      tc_d  = 1'b0;
      ld_en = 1'b1;
    end else if (adv_i && !tc_q) begin
      ld_en = 1'b1;
      if (cnt_q == LAST) begin
        tc_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tc_q  <= 1'b0;
    end else if (ld_en) begin
      cnt_q <= cnt_d;
      tc_q  <= tc_d;
    end
  end

  assign cnt_o = cnt_q;
  assign tc_o  = tc_q;

endmodule

// File: rtl/sercfg_store.sv
module sercfg_store #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic          wr_bit_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          rd_bit_o
);

  logic [DEPTH-1:0] mem_bits;

  // One flop per stored bit, each with its own decoded clock enable.
  // Indices at or above DEPTH match no cell and are dropped.
  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic cell_q;
    logic cell_en;

    assign cell_en = wr_en_i && (wr_addr_i == AW'(i));

    always_ff @(posedge clk_i) begin
      if (cell_en) begin
        cell_q <= wr_bit_i;
      end
    end

    assign mem_bits[i] = cell_q;
  end

  assign rd_bit_o = mem_bits[rd_addr_i];

endmodule

// File: rtl/sercfg_out_gate.sv
module sercfg_out_gate (
  input  logic ce_ni,
  input  logic oe_act_i,
  input  logic tc_i,
  input  logic bit_i,
  output logic data_o,
  output logic data_oe_o,
  output logic ceo_no
);

  logic drive;

  // Drive only when selected, enabled and still inside the image.
  assign drive     = !ce_ni && oe_act_i && !tc_i;
  assign data_oe_o = drive;
  assign data_o    = drive & bit_i;
  assign ceo_no    = !tc_i;

endmodule

// File: rtl/sercfg_mem.sv
module sercfg_mem
  import sercfg_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter rst_pol_e    RST_POL = RST_ACT_LOW,
  localparam int unsigned AW     = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          oe_rst_i,
  input  logic          ld_we_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic          ld_bit_i,
  output logic          data_o,
  output logic          data_oe_o,
  output logic          ceo_no
);

  logic          rst_act;
  logic [AW-1:0] cnt_q;
  logic          tc_q;
  logic          rd_bit;
  logic          wr_en;

  assign rst_act = pol_asserted(RST_POL, oe_rst_i);
  assign wr_en   = ld_we_i && rst_act;

  sercfg_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rst_act),
    .adv_i  (!ce_ni),
    .cnt_o  (cnt_q),
    .tc_o   (tc_q)
  );

  sercfg_store #(.DEPTH(DEPTH)) u_mem (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_addr_i (ld_addr_i),
    .wr_bit_i  (ld_bit_i),
    .rd_addr_i (cnt_q),
    .rd_bit_o  (rd_bit)
  );

  sercfg_out_gate u_out (
    .ce_ni     (ce_ni),
    .oe_act_i  (!rst_act),
    .tc_i      (tc_q),
    .bit_i     (rd_bit),
    .data_o    (data_o),
    .data_oe_o (data_oe_o),
    .ceo_no    (ceo_no)
  );

endmodule

// File: rtl/sercfg_mem_chk.sv
module sercfg_mem_chk
  import sercfg_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter rst_pol_e    RST_POL = RST_ACT_LOW,
  localparam int unsigned AW     = $clog2(DEPTH)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_ni,
  input logic          oe_rst_i,
  input logic          data_oe_o,
  input logic          ceo_no,
  input logic [AW-1:0] cnt_q
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic in_rst;
  assign in_rst = (RST_POL == RST_ACT_HIGH) ? oe_rst_i : !oe_rst_i;

  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !in_rst && ceo_no && cnt_q != LAST) |=> cnt_q == AW'($past(cnt_q) + 1'b1));

  p_ce_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni && !in_rst) |=> $stable(cnt_q));

  p_drive_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!ce_ni && !in_rst && ceo_no));

  p_reset_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_rst |=> (cnt_q == '0 && ceo_no));

  p_tc_reached_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !in_rst && ceo_no && cnt_q == LAST) |=> !ceo_no);

  p_tc_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ceo_no && !in_rst) |=> (!ceo_no && $stable(cnt_q)));

endmodule

bind sercfg_mem sercfg_mem_chk #(.DEPTH(DEPTH), .RST_POL(RST_POL)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ce_ni     (ce_ni),
  .oe_rst_i  (oe_rst_i),
  .data_oe_o (data_oe_o),
  .ceo_no    (ceo_no),
  .cnt_q     (cnt_q)
);

// File: tb/sim_sercfg_mem.sv
module sim_sercfg_mem;
  import sercfg_pkg::*;

  localparam int D0 = 12;
  localparam int D1 = 8;
  localparam int TOTAL = D0 + D1;
  localparam logic [D0-1:0] IMG0 = 12'hA5C;
  localparam logic [D1-1:0] IMG1 = 8'h3B;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_rst;         // logical reset request; pin levels derived per polarity
  logic ce0_n;
  logic we0, we1;
  logic [3:0] la0;
  logic [2:0] la1;
  logic lb;

  logic d0, oe0, ceo0_n;
  logic d1, oe1, ceo1_n;
  logic line;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;  // 250 MHz

  // Instance 0: reset when its pin is low. Instance 1: reset when its pin is high.
  sercfg_mem #(.DEPTH(D0), .RST_POL(RST_ACT_LOW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce0_n), .oe_rst_i(~cfg_rst),
    .ld_we_i(we0), .ld_addr_i(la0), .ld_bit_i(lb),
    .data_o(d0), .data_oe_o(oe0), .ceo_no(ceo0_n));

  sercfg_mem #(.DEPTH(D1), .RST_POL(RST_ACT_HIGH)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ceo0_n), .oe_rst_i(cfg_rst),
    .ld_we_i(we1), .ld_addr_i(la1), .ld_bit_i(lb),
    .data_o(d1), .data_oe_o(oe1), .ceo_no(ceo1_n));

  assign line = (oe0 & d0) | (oe1 & d1);

  function automatic logic exp_bit(int k);
    return (k < D0) ? IMG0[k] : IMG1[k - D0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // R9, R5, R1: state coming out of reset, both polarities held in reset
  task automatic t_reset();
    rst_n = 1'b0; cfg_rst = 1'b1; ce0_n = 1'b1;
    we0 = 1'b0; we1 = 1'b0; la0 = '0; la1 = '0; lb = 1'b0;
    repeat (3) step();
    chk("R9 ceo0 after rst_ni", ceo0_n, 1);
    chk("R9 ceo1 after rst_ni", ceo1_n, 1);
    @(negedge clk) rst_n = 1'b1; ce0_n = 1'b0;
    #1;
    chk("R1 u0 low pin no drive", oe0, 0);
    chk("R1 u1 high pin no drive", oe1, 0);
    step();
    chk("R5 ceo0 in reset", ceo0_n, 1);
    @(negedge clk) ce0_n = 1'b1;
  endtask

  // R7: fill both images while in reset, plus out-of-range writes
  task automatic t_load();
    for (int a = 0; a < D0; a++) begin
      @(negedge clk) we0 = 1'b1; la0 = 4'(a); lb = IMG0[a];
    end
    for (int a = D0; a < 16; a++) begin
      @(negedge clk) we0 = 1'b1; la0 = 4'(a); lb = ~IMG0[a - D0];  // R7 out of range
    end
    @(negedge clk) we0 = 1'b0;
    for (int a = 0; a < D1; a++) begin
      @(negedge clk) we1 = 1'b1; la1 = 3'(a); lb = IMG1[a];
    end
    @(negedge clk) we1 = 1'b0;
  endtask

  // R3, R7: released from reset but not selected; write attempt outside reset
  task automatic t_ce_hold();
    @(negedge clk) cfg_rst = 1'b0;
    #1;
    chk("R3 oe0 low while ce high", oe0, 0);
    @(negedge clk) we0 = 1'b1; la0 = 4'd1; lb = ~IMG0[1];   // R7 must be ignored
    #1;
    chk("R3 ceo0 stays high", ceo0_n, 1);
    @(negedge clk) we0 = 1'b0;
    repeat (2) step();
    chk("R3 oe1 idle", oe1, 0);
  endtask

  // R2, R3, R4, R6, R7, R8: full chained stream with a pause
  task automatic t_stream();
    @(negedge clk) ce0_n = 1'b0;
    #1;
    chk("R8 one driver k0", 32'(oe0) + 32'(oe1), 1);
    chk("R4 first bit", line, exp_bit(0));
    for (int k = 1; k < 5; k++) begin
      step();
      chk("R2 R8 single driver", 32'(oe0) + 32'(oe1), 1);
      chk("R2 R7 stream bit", line, exp_bit(k));
    end
    @(negedge clk) ce0_n = 1'b1;
    #1;
    chk("R3 pause no drive", 32'(oe0) + 32'(oe1), 0);
    step();
    chk("R3 pause still no drive", 32'(oe0) + 32'(oe1), 0);
    @(negedge clk) ce0_n = 1'b0;
    #1;
    chk("R3 resume same bit", line, exp_bit(5));
    for (int k = 6; k < TOTAL; k++) begin
      step();
      chk("R8 single driver", 32'(oe0) + 32'(oe1), 1);
      chk("R8 concatenated bit", line, exp_bit(k));
      if (k == D0) chk("R6 ceo0 low at handoff", ceo0_n, 0);
    end
    for (int n = 0; n < 3; n++) begin
      step();
      chk("R6 no driver after end", 32'(oe0) + 32'(oe1), 0);
      chk("R6 ceo0 sticky", ceo0_n, 0);
      chk("R6 ceo1 low", ceo1_n, 0);
    end
  endtask

  // R5, R9, R1: restart through the shared pin, then through rst_ni
  task automatic t_restart();
    @(negedge clk) cfg_rst = 1'b1;
    #1;
    chk("R4 no drive in reset", 32'(oe0) + 32'(oe1), 0);
    step();
    chk("R5 ceo0 back high", ceo0_n, 1);
    chk("R5 ceo1 back high", ceo1_n, 1);
    @(negedge clk) cfg_rst = 1'b0;
    #1;
    chk("R5 restart bit0", line, exp_bit(0));
    chk("R1 u0 enabled at high pin", oe0, 1);
    step();
    step();
    chk("R2 restart bit2", line, exp_bit(2));
    rst_n = 1'b0;
    #1;
    chk("R9 async clear drives bit0", line, exp_bit(0));
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R9 held at bit0", line, exp_bit(0));
    step();
    chk("R2 after rst_ni bit1", line, exp_bit(1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_ce_hold();
    t_stream();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule